// File: doc/BRIEF.md
# Millivolt Seven-Segment Readout

This block turns a 12-bit unsigned converter code into a voltage reading on four multiplexed seven-segment digits, in the form x.yyy volts. A full-scale code stands for 3.3 V. The code is first scaled to whole millivolts using only integer multiply-and-shift. A sequential binary-to-BCD converter then turns that value into four decimal digits. A scan controller lights the digits one at a time, with a fixed decimal point after the leftmost digit.

The block has three internal stages, each with its own state machine or register:
- `mv_scaler` registers the millivolt value one cycle after the code.
- `bcd_converter` cycles through the states CV_LOAD, CV_SHIFT and CV_PUBLISH. The transitions are: CV_LOAD goes to CV_SHIFT on the next cycle; CV_SHIFT stays for twelve cycles, then goes to CV_PUBLISH; CV_PUBLISH goes back to CV_LOAD. New digits reach the display register only in CV_PUBLISH.
- `digit_scanner` alternates between SC_BLANK and SC_SHOW. SC_BLANK goes to SC_SHOW after one prescaler tick. SC_SHOW goes back to SC_BLANK after `SHOW_TICKS` ticks, and at that point moves to the next digit.

A prescaler of `SCAN_DIV` clocks sets the tick rate.

Top module: `volt_readout`

## Requirements
- R1: The displayed value equals floor(code × 3300 / 4096) millivolts. Code 2097 shows 1689, code 4095 shows 3299, and the internal millivolt value never exceeds 3299.
- R2: The value is shown in decimal with the integer volt digit on digit index 3 and the three fraction digits on indices 2, 1 and 0. Leading zeros are shown, so code 0 reads 0.000.
- R3: `seg_n[6:0]` is active-low in the order {g,f,e,d,c,b,a}. With active-high notation, the digits 0 to 9 are 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F and 6F hex.
- R4: At most one bit of the active-low `dig_n` is low at any time. Bit i enables digit index i.
- R5: `dp_n` is low only while digit index 3 (`dig_n[3]`) is enabled, and is low for every cycle that digit is enabled.
- R6: Between two different enabled digits there is at least one cycle with all digits off. While all digits are off, `seg_n` is all ones and `dp_n` is high.
- R7: Every digit is enabled at least once in every 4×(1+SHOW_TICKS)×SCAN_DIV + 4 clock cycles.
- R8: After a code change, each shown digit belongs either to the previous value or to the new value. No mix of the two appears within a single digit. From the 30th cycle after the change, every digit belongs to the new value.
- R9: While synchronous reset is high, all digits, segments and the decimal point are off. After reset, the display reads 0.000 until the first conversion is published.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| code | input | CODE_W | Unsigned converter code |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} |
| dp_n | output | 1 | Active-low decimal point |
| dig_n | output | 4 | Active-low digit enables, bit 3 leftmost |

## Verification
The bench builds the block with `SCAN_DIV` = 2 and `SHOW_TICKS` = 1, so a full rotation over all four digits takes 16 clocks. With that setting, a hold of 33 cycles per code is enough to sweep all 4096 codes. Each hold covers the old-or-new transition window and the settled window, and the scan order, blanking gaps and refresh deadline are exercised thousands of times. The default prescaler of tens of thousands of cycles would allow only a handful of codes in the same run.

// File: rtl/volt_pkg.sv
package volt_pkg;

    localparam int NUM_DIGITS = 4;
    localparam int DP_INDEX   = NUM_DIGITS - 1;

    typedef enum logic [1:0] {
        CV_LOAD,
        CV_SHIFT,
        CV_PUBLISH
    } cv_state_t;

    typedef enum logic {
        SC_BLANK,
        SC_SHOW
    } scan_state_t;

    // Active-high glyph, bit order {g,f,e,d,c,b,a}
    function automatic logic [6:0] glyph_of(input logic [3:0] bcd);
        logic [6:0] g;
        unique case (bcd)
            4'd0:    g = 7'h3F;
            4'd1:    g = 7'h06;
            4'd2:    g = 7'h5B;
            4'd3:    g = 7'h4F;
            4'd4:    g = 7'h66;
            4'd5:    g = 7'h6D;
            4'd6:    g = 7'h7D;
            4'd7:    g = 7'h07;
            4'd8:    g = 7'h7F;
            4'd9:    g = 7'h6F;
            default: g = 7'h40;
        endcase
        return g;
    endfunction

endpackage

// File: rtl/mv_scaler.sv
module mv_scaler #(
    parameter int CODE_W  = 12,
    parameter int FULL_MV = 3300,
    parameter int MV_W    = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic [MV_W-1:0]   mv
);
    localparam int PROD_W = CODE_W + $clog2(FULL_MV + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            mv <= '0;
        end else begin
            mv <= MV_W'((PROD_W'(code) * PROD_W'(FULL_MV)) >> CODE_W);
        end
    end
endmodule

// File: rtl/bcd_converter.sv
module bcd_converter
    import volt_pkg::*;
#(
    parameter int BIN_W  = 12,
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [BIN_W-1:0]      bin_in,
    output logic [DIGITS*4-1:0]   digits_out
);
    localparam int BCD_W = DIGITS * 4;
    localparam int CNT_W = (BIN_W > 1) ? $clog2(BIN_W) : 1;
    localparam int SH_W  = BCD_W + BIN_W;

    cv_state_t          state, nxt;
    logic [SH_W-1:0]    shreg;
    logic [CNT_W-1:0]   cnt;
    logic [BCD_W-1:0]   adj_bcd;

    // add-3 correction on every nibble before the shift
    for (genvar g = 0; g < DIGITS; g++) begin : g_adj
        logic [3:0] nib;
        assign nib = shreg[BIN_W + g*4 +: 4];
        assign adj_bcd[g*4 +: 4] = (nib >= 4'd5) ? nib + 4'd3 : nib;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= CV_LOAD;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            CV_LOAD:    nxt = CV_SHIFT;
            CV_SHIFT:   if (cnt == CNT_W'(BIN_W - 1)) nxt = CV_PUBLISH;
            CV_PUBLISH: nxt = CV_LOAD;
            default:    nxt = CV_LOAD;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg      <= '0;
            cnt        <= '0;
            digits_out <= '0;
        end else begin
            unique case (state)
                CV_LOAD: begin
                    shreg <= {{BCD_W{1'b0}}, bin_in};
                    cnt   <= '0;
                end
                CV_SHIFT: begin
                    shreg <= {adj_bcd, shreg[BIN_W-1:0]} << 1;
                    cnt   <= cnt + 1'b1;
                end
                CV_PUBLISH: begin
                    digits_out <= shreg[BIN_W +: BCD_W];
                end
                default: begin
                    cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/digit_scanner.sv
module digit_scanner
    import volt_pkg::*;
#(
    parameter int DIGITS     = 4,
    parameter int SCAN_DIV   = 31250,
    parameter int SHOW_TICKS = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [DIGITS*4-1:0]  digits_in,
    output logic [6:0]           seg_n,
    output logic                 dp_n,
    output logic [DIGITS-1:0]    dig_n
);
    localparam int PW    = (SCAN_DIV > 1)   ? $clog2(SCAN_DIV)   : 1;
    localparam int SW    = (SHOW_TICKS > 1) ? $clog2(SHOW_TICKS) : 1;
    localparam int SEL_W = (DIGITS > 1)     ? $clog2(DIGITS)     : 1;

    scan_state_t        state, nxt;
    logic [PW-1:0]      presc;
    logic               tick;
    logic [SW-1:0]      show_cnt;
    logic [SEL_W-1:0]   sel;
    logic               last_show;

    assign tick      = (presc == PW'(SCAN_DIV - 1));
    assign last_show = (show_cnt == SW'(SHOW_TICKS - 1));

    always_ff @(posedge clk) begin
        if (rst)       presc <= '0;
        else if (tick) presc <= '0;
        else           presc <= presc + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) state <= SC_BLANK;
        else     state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            SC_BLANK: if (tick) nxt = SC_SHOW;
            SC_SHOW:  if (tick && last_show) nxt = SC_BLANK;
            default:  nxt = SC_BLANK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel      <= '0;
            show_cnt <= '0;
        end else if (tick) begin
            if (state == SC_BLANK) begin
                show_cnt <= '0;
            end else if (last_show) begin
                sel <= (sel == SEL_W'(DIGITS - 1)) ? '0 : sel + 1'b1;
            end else begin
                show_cnt <= show_cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dig_n <= '1;
            seg_n <= '1;
            dp_n  <= 1'b1;
        end else if (state == SC_SHOW) begin
            dig_n <= ~(DIGITS'(1) << sel);
            seg_n <= ~glyph_of(digits_in[sel*4 +: 4]);
            dp_n  <= !(sel == SEL_W'(DP_INDEX));
        end else begin
            dig_n <= '1;
            seg_n <= '1;
            dp_n  <= 1'b1;
        end
    end
endmodule

// File: rtl/volt_readout.sv
module volt_readout
    import volt_pkg::*;
#(
    parameter int CODE_W     = 12,
    parameter int FULL_MV    = 3300,
    parameter int SCAN_DIV   = 31250,
    parameter int SHOW_TICKS = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    output logic [6:0]        seg_n,
    output logic              dp_n,
    output logic [3:0]        dig_n
);
    localparam int MV_W = $clog2(FULL_MV);

    logic [MV_W-1:0]         mv_val;
    logic [NUM_DIGITS*4-1:0] shown_bcd;

    mv_scaler #(
        .CODE_W (CODE_W),
        .FULL_MV(FULL_MV),
        .MV_W   (MV_W)
    ) u_scale (
        .clk (clk),
        .rst (rst),
        .code(code),
        .mv  (mv_val)
    );

    bcd_converter #(
        .BIN_W (MV_W),
        .DIGITS(NUM_DIGITS)
    ) u_bcd (
        .clk       (clk),
        .rst       (rst),
        .bin_in    (mv_val),
        .digits_out(shown_bcd)
    );

    digit_scanner #(
        .DIGITS    (NUM_DIGITS),
        .SCAN_DIV  (SCAN_DIV),
        .SHOW_TICKS(SHOW_TICKS)
    ) u_scan (
        .clk      (clk),
        .rst      (rst),
        .digits_in(shown_bcd),
        .seg_n    (seg_n),
        .dp_n     (dp_n),
        .dig_n    (dig_n)
    );
endmodule

// File: rtl/volt_readout_chk.sv
module volt_readout_chk #(
    parameter int FULL_MV = 3300,
    parameter int MV_W    = 12
) (
    input logic            clk,
    input logic            rst,
    input logic [3:0]      dig_n,
    input logic [6:0]      seg_n,
    input logic            dp_n,
    input logic [MV_W-1:0] mv_val
);
    function automatic logic legal_glyph(input logic [6:0] s);
        logic [6:0] a;
        a = ~s;
        return a == 7'h3F || a == 7'h06 || a == 7'h5B || a == 7'h4F ||
               a == 7'h66 || a == 7'h6D || a == 7'h7D || a == 7'h07 ||
               a == 7'h7F || a == 7'h6F;
    endfunction

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        32'(mv_val) <= FULL_MV - 1);

    // R3
    legal_glyph_chk: assert property (@(posedge clk) disable iff (rst)
        !(&dig_n) |-> legal_glyph(seg_n));

    // R4
    one_digit_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~dig_n));

    // R5
    dp_lead_chk: assert property (@(posedge clk) disable iff (rst)
        !dp_n |-> !dig_n[3]);

    // R6
    blank_gap_chk: assert property (@(posedge clk) disable iff (rst)
        !(&dig_n) |=> ((&dig_n) || $stable(dig_n)));

    // R6
    blank_dark_chk: assert property (@(posedge clk) disable iff (rst)
        (&dig_n) |-> ((&seg_n) && dp_n));
endmodule

bind volt_readout volt_readout_chk #(
    .FULL_MV(FULL_MV),
    .MV_W   (MV_W)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .dig_n (dig_n),
    .seg_n (seg_n),
    .dp_n  (dp_n),
    .mv_val(mv_val)
);

// File: tb/volt_readout_test.sv
module volt_readout_test;
    localparam int DIV     = 2;
    localparam int SHOW    = 1;
    localparam int MAX_GAP = 4 * (1 + SHOW) * DIV + 4;
    localparam int SETTLE  = 30;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [11:0] code = '0;
    logic [6:0]  seg_n;
    logic        dp_n;
    logic [3:0]  dig_n;

    always #4 clk = ~clk;

    volt_readout #(.SCAN_DIV(DIV), .SHOW_TICKS(SHOW)) uut (
        .clk(clk), .rst(rst), .code(code),
        .seg_n(seg_n), .dp_n(dp_n), .dig_n(dig_n)
    );

    int    vectors = 0;
    int    fails   = 0;
    int    cur_exp = 0;
    int    old_exp = 0;
    int    age     = 0;
    int    prev_idx = -1;
    int    gap [4];
    bit    chk_on  = 0;
    bit    done    = 0;
    string tag     = "R9";

    function automatic int ref_mv(input int c);
        return (c * 3300) / 4096;
    endfunction

    function automatic int digit_at(input int v, input int idx);
        int p = 1;
        for (int k = 0; k < idx; k++) p = p * 10;
        return (v / p) % 10;
    endfunction

    function automatic logic [6:0] glyph(input int d);
        case (d)
            0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B;
            3: return 7'h4F; 4: return 7'h66; 5: return 7'h6D;
            6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F;
            default: return 7'h6F;
        endcase
    endfunction

    task automatic fail(input string t, input int act, input int exp);
        fails++;
        $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
    endtask

    // per-clock comparison against the behavioural model
    always @(negedge clk) begin
        if (chk_on) begin
            int n;
            int idx;
            logic [6:0] want_new;
            logic [6:0] want_old;
            n = 0;
            idx = -1;
            age++;
            vectors++;
            for (int d = 0; d < 4; d++) begin
                if (!dig_n[d]) begin
                    n++;
                    idx = d;
                end
            end
            if (n > 1) begin
                fail("R4", int'(dig_n), 0);
            end else if (n == 1) begin
                if (prev_idx >= 0 && prev_idx != idx)
                    fail("R6", idx, prev_idx);
                want_new = ~glyph(digit_at(cur_exp, idx));
                want_old = ~glyph(digit_at(old_exp, idx));
                // R1 R2 R3 R8: new value always accepted, old only inside window
                if (!(seg_n == want_new || (age < SETTLE && seg_n == want_old)))
                    fail(age < SETTLE ? "R8" : tag, int'(seg_n), int'(want_new));
                // R5
                if (dp_n != (idx != 3))
                    fail("R5", int'(dp_n), int'(idx != 3));
            end else begin
                // R6 dark while blanked
                if (seg_n != 7'h7F || dp_n != 1'b1)
                    fail("R6", int'({dp_n, seg_n}), 8'hFF);
            end
            prev_idx = (n == 1) ? idx : -1;
            // R7 refresh deadline
            for (int d = 0; d < 4; d++) begin
                if (!dig_n[d]) gap[d] = 0;
                else gap[d]++;
                if (gap[d] > MAX_GAP) begin
                    fail("R7", gap[d], MAX_GAP);
                    gap[d] = 0;
                end
            end
        end
    end

    task automatic apply(input int c, input int hold, input string t);
        @(posedge clk);
        #1;
        old_exp = cur_exp;
        code    = 12'(c);
        cur_exp = ref_mv(c);
        age     = 0;
        tag     = t;
        repeat (hold) @(posedge clk);
    endtask

    initial begin
        for (int d = 0; d < 4; d++) gap[d] = 0;
        code = 12'd4095;
        repeat (5) begin
            @(negedge clk);
            vectors++;
            // R9 outputs dark in reset
            if (dig_n != 4'hF || seg_n != 7'h7F || dp_n != 1'b1)
                fail("R9", int'({dig_n, dp_n, seg_n}), 12'hFFF);
        end
        code = '0;
        @(posedge clk);
        #1;
        rst     = 1'b0;
        age     = 0;
        chk_on  = 1'b1;
        // R9 then R2: zero reads 0.000, including before first publish
        apply(0, 80, "R2");
        apply(2097, 80, "R1");
        apply(4095, 80, "R1");
        apply(1000, 80, "R2");
        apply(4, 80, "R2");
        apply(3103, 80, "R3");
        // R1 full sweep of every code
        for (int c = 0; c < 4096; c++) apply(c, 33, "R1");
        apply(0, 40, "R2");
        chk_on = 1'b0;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule